// File: doc/BRIEF.md
# Special Cycle Decoder and Responder

This block sits on the system-logic side of a processor bus and watches every address-strobe clock. When the cycle-type lines mark a special cycle (control, I/O, write), it sorts the cycle into one of seven kinds. It uses the byte-lane enables and the address bits above bit 2 to do this. A clock later than the strobe that is set by a parameter, it pulls the active-low burst-ready line for one clock, and it raises one event pulse for the decoded kind in that same clock.

Any special cycle whose encoding is not in the table still gets its ready. In that case an error pulse replaces the event pulse, so the processor never stalls on an odd encoding. Halt and stop grant share the same byte-lane value, and only address bits 4:3 separate them. Memory, I/O and other non-special cycles are left to other responders: this block neither answers them nor reports them.

Only one special cycle is tracked at a time. Strobes that arrive while a cycle is still waiting for its ready are dropped. A new strobe that falls in the clock that carries the ready is taken.

Top module: `spcyc_responder`

## Requirements
- R1: A special cycle is taken on a rising clock edge where strobe_n = 0, kind_dc = 0, kind_mem = 0 and kind_wr = 1.
- R2: For each taken special cycle, done_n is 0 for exactly one clock. That clock is the RDY_LAT-th clock after the strobe clock (default RDY_LAT = 1, which is the clock right after it). At all other times done_n is 1.
- R3: lane_en_n = 8'hFB with bus_addr[4:3] = 2'b00 decodes as halt and pulses evt_o bit 4.
- R4: lane_en_n = 8'hFB with bus_addr[4:3] = 2'b10 decodes as stop grant and pulses evt_o bit 0.
- R5: With bus_addr[4:3] = 2'b00, lane_en_n of 8'hBF, 8'hEF, 8'hF7, 8'hFD and 8'hFE pulse evt_o bits 1 (power-management stop grant), 2 (flush acknowledge), 3 (writeback), 5 (flush) and 6 (shutdown).
- R6: A special cycle with any of bus_addr[31:5] set, or with a byte-lane and address-bit pair not listed in R3 to R5, pulses err_o with evt_o = 0, and still gets its done_n clock.
- R7: evt_o and err_o are 0 except in the done_n clock. In that clock exactly one bit of {err_o, evt_o} is 1.
- R8: A strobe clock that is not a special cycle produces no done_n, no event and no error.
- R9: A strobe that comes while an earlier special cycle is waiting for its done_n clock is ignored. A strobe that comes in the done_n clock itself is taken as a new cycle.
- R10: While reset is asserted, and until the first taken cycle, done_n = 1 and evt_o, err_o = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-flop synchronizer |
| strobe_n | input | 1 | Address strobe, active low |
| kind_dc | input | 1 | Data (1) or control (0) cycle |
| kind_mem | input | 1 | Memory (1) or I/O (0) cycle |
| kind_wr | input | 1 | Write (1) or read (0) cycle |
| lane_en_n | input | 8 | Byte-lane enables, active low |
| bus_addr | input | ADDR_W-3 (29) | Address bits ADDR_W-1 down to 3 |
| done_n | output | 1 | Burst-ready response, active low |
| evt_o | output | 7 | One-hot decoded special-cycle pulse |
| err_o | output | 1 | Unrecognised special-cycle pulse |

## Verification
Two functions can fall in the same clock: the ready answer for one special cycle and the strobe of the next one. The bench provokes this by driving a second strobe exactly in the clock it expects done_n low for the first. It judges the result by requiring both the first cycle's event and a later, separate ready carrying the second cycle's event. Strobes sent in the clocks between a take and its ready must leave no trace on the outputs.

// File: rtl/spcyc_pkg.sv
package spcyc_pkg;

  localparam int EVT_N = 7;

  // bit position of each kind inside the event vector
  typedef enum int {
    EV_STOPGNT  = 0,
    EV_PMSTOP   = 1,
    EV_FLUSHACK = 2,
    EV_WBACK    = 3,
    EV_HALT     = 4,
    EV_FLUSH    = 5,
    EV_SHUTDN   = 6
  } evt_pos_e;

  typedef struct packed {
    logic             err;
    logic [EVT_N-1:0] evt;
  } cls_t;

endpackage

// File: rtl/spcyc_qualify.sv
module spcyc_qualify (
  input  logic strobe_n,
  input  logic kind_dc,
  input  logic kind_mem,
  input  logic kind_wr,
  output logic special_o
);

  always_comb begin
    special_o = ~strobe_n & ~kind_dc & ~kind_mem & kind_wr;
  end

endmodule

// File: rtl/spcyc_decode.sv
module spcyc_decode
  import spcyc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [7:0]        lane_en_n,
  input  logic [ADDR_W-1:3] bus_addr,
  output cls_t              cls_o
);

  logic       hi_zero;
  logic [1:0] sel;
  logic [EVT_N-1:0] evt;

  always_comb begin
    hi_zero = ~|bus_addr[ADDR_W-1:5];
    sel     = bus_addr[4:3];
    evt     = '0;
    if (hi_zero) begin
      if (sel == 2'b10) begin
        if (lane_en_n == 8'hFB) evt[EV_STOPGNT] = 1'b1;
      end else if (sel == 2'b00) begin
        case (lane_en_n)
          8'hFB:   evt[EV_HALT]     = 1'b1;
          8'hBF:   evt[EV_PMSTOP]   = 1'b1;
          8'hEF:   evt[EV_FLUSHACK] = 1'b1;
          8'hF7:   evt[EV_WBACK]    = 1'b1;
          8'hFD:   evt[EV_FLUSH]    = 1'b1;
          8'hFE:   evt[EV_SHUTDN]   = 1'b1;
          default: evt = '0;
        endcase
      end
    end
    cls_o.evt = evt;
    cls_o.err = ~|evt;
  end

endmodule

// File: rtl/spcyc_timer.sv
module spcyc_timer #(
  parameter int RDY_LAT = 1
) (
  input  logic clk,
  input  logic rst_i,
  input  logic special_i,
  output logic accept_o,
  output logic fire_o
);

  localparam int CW = (RDY_LAT > 2) ? $clog2(RDY_LAT) : 1;

  generate
    if (RDY_LAT <= 1) begin : g_direct
      // answer in the clock right after the strobe: nothing to wait for
      always_comb begin
        accept_o = special_i;
        fire_o   = special_i;
      end
    end else begin : g_count
      logic          pend_q, pend_d;
      logic [CW-1:0] cnt_q, cnt_d;
      logic          fire_d;

      always_comb begin
        accept_o = special_i & ~pend_q;
        pend_d   = pend_q;
        cnt_d    = cnt_q;
        fire_d   = 1'b0;
        if (pend_q) begin
          cnt_d = cnt_q - 1'b1;
          if (cnt_q == CW'(1)) begin
            fire_d = 1'b1;
            pend_d = 1'b0;
          end
        end else if (accept_o) begin
          pend_d = 1'b1;
          cnt_d  = CW'(RDY_LAT - 1);
        end
        fire_o = fire_d;
      end

      always_ff @(posedge clk or negedge rst_i) begin
        if (!rst_i) begin
          pend_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          pend_q <= pend_d;
          cnt_q  <= cnt_d;
        end
      end

      AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_i)
        (pend_q && !fire_d) |=> pend_q) else $error("pending cycle lost"); // R9
    end
  endgenerate

endmodule

// File: rtl/spcyc_responder.sv
module spcyc_responder
  import spcyc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int RDY_LAT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_n,
  input  logic              kind_dc,
  input  logic              kind_mem,
  input  logic              kind_wr,
  input  logic [7:0]        lane_en_n,
  input  logic [ADDR_W-1:3] bus_addr,
  output logic              done_n,
  output logic [EVT_N-1:0]  evt_o,
  output logic              err_o
);

  // reset: asserted at once, released on the clock
  logic [1:0] rsync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  logic special, accept, fire;
  cls_t cls_now, cls_src;

  spcyc_qualify u_qual (
    .strobe_n (strobe_n),
    .kind_dc  (kind_dc),
    .kind_mem (kind_mem),
    .kind_wr  (kind_wr),
    .special_o(special)
  );

  spcyc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .lane_en_n(lane_en_n),
    .bus_addr (bus_addr),
    .cls_o    (cls_now)
  );

  spcyc_timer #(.RDY_LAT(RDY_LAT)) u_tmr (
    .clk      (clk),
    .rst_i    (rst_i),
    .special_i(special),
    .accept_o (accept),
    .fire_o   (fire)
  );

  generate
    if (RDY_LAT <= 1) begin : g_pass
      always_comb cls_src = cls_now;
    end else begin : g_hold
      cls_t hold_q;
      always_ff @(posedge clk or negedge rst_i) begin
        if (!rst_i)      hold_q <= '0;
        else if (accept) hold_q <= cls_now;
      end
      always_comb cls_src = hold_q;
    end
  endgenerate

  // output stage: next state, then register
  logic             done_d, err_d;
  logic [EVT_N-1:0] evt_d;

  always_comb begin
    done_d = ~fire;
    evt_d  = fire ? cls_src.evt : '0;
    err_d  = fire & cls_src.err;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      done_n <= 1'b1;
      evt_o  <= '0;
      err_o  <= 1'b0;
    end else begin
      done_n <= done_d;
      evt_o  <= evt_d;
      err_o  <= err_d;
    end
  end

  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_i)
    !done_n |-> ($countones({err_o, evt_o}) == 1)) else $error("class not one-hot"); // R7
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_i)
    done_n |-> ({err_o, evt_o} == '0)) else $error("pulse without ready"); // R7

  generate
    if (RDY_LAT <= 1) begin : g_chk_direct
      AST_NONSPECIAL_SILENT: assert property (@(posedge clk) disable iff (!rst_i)
        (strobe_n || kind_dc || kind_mem || !kind_wr) |=> done_n)
        else $error("ready on non-special"); // R8
      AST_HIGH_ADDR_ERR: assert property (@(posedge clk) disable iff (!rst_i)
        (!strobe_n && !kind_dc && !kind_mem && kind_wr && (|bus_addr[ADDR_W-1:5])) |=> (err_o && !done_n))
        else $error("high address not flagged"); // R6
    end else begin : g_chk_count
      AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_i)
        !done_n |=> done_n) else $error("ready longer than one clock"); // R2
    end
  endgenerate

endmodule

// File: tb/sim_spcyc_responder.sv
`timescale 1ns/1ps
module sim_spcyc_responder;

  localparam int LAT    = 3;
  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic strobe_n, kind_dc, kind_mem, kind_wr;
  logic [7:0] lane_en_n;
  logic [ADDR_W-1:0] addr_full;
  logic done_n, err_o;
  logic [6:0] evt_o;

  always #2.5 clk = ~clk;

  spcyc_responder #(.ADDR_W(ADDR_W), .RDY_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .kind_dc(kind_dc),
    .kind_mem(kind_mem), .kind_wr(kind_wr), .lane_en_n(lane_en_n),
    .bus_addr(addr_full[ADDR_W-1:3]), .done_n(done_n), .evt_o(evt_o), .err_o(err_o)
  );

  typedef struct { int due; logic err; logic [6:0] evt; string req; } exp_t;
  exp_t sb[$];

  int checks = 0, errors = 0, cyc = 0, last_due = -1;
  bit mon_on = 1'b0, finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares each clock against the scoreboard head
  always @(negedge clk) begin
    if (mon_on) begin
      checks++;
      if (sb.size() > 0 && sb[0].due == cyc) begin
        if (done_n !== 1'b0 || evt_o !== sb[0].evt || err_o !== sb[0].err) begin
          errors++;
          $display("FAIL %s: done_n=%b evt=%b err=%b expected done_n=0 evt=%b err=%b",
                   sb[0].req, done_n, evt_o, err_o, sb[0].evt, sb[0].err);
        end
        void'(sb.pop_front());
      end else if (done_n !== 1'b1 || evt_o !== 7'd0 || err_o !== 1'b0) begin
        errors++;
        $display("FAIL R2/R8/R9 stray: done_n=%b evt=%b err=%b expected done_n=1 evt=0 err=0",
                 done_n, evt_o, err_o);
      end
    end
  end

  task automatic idle(input int n);
    strobe_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  // driver: presents one strobe clock and queues the expected answer
  task automatic send(input logic dc, input logic mem, input logic wr,
                      input logic [7:0] lanes, input logic [31:0] a,
                      input logic xerr, input logic [6:0] xevt, input string req);
    int s;
    exp_t e;
    strobe_n = 1'b0; kind_dc = dc; kind_mem = mem; kind_wr = wr;
    lane_en_n = lanes; addr_full = a;
    s = cyc + 1;
    if (!dc && !mem && wr && s > last_due) begin
      e.due = s + LAT - 1; e.err = xerr; e.evt = xevt; e.req = req;
      sb.push_back(e);
      last_due = e.due;
    end
    @(negedge clk);
    strobe_n = 1'b1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; strobe_n = 1'b1; kind_dc = 1'b1; kind_mem = 1'b1; kind_wr = 1'b0;
    lane_en_n = 8'hFF; addr_full = '0;
    repeat (3) @(negedge clk);
    checks++;   // R10 reset state
    if (done_n !== 1'b1 || evt_o !== 7'd0 || err_o !== 1'b0) begin
      errors++;
      $display("FAIL R10: done_n=%b evt=%b err=%b expected 1 0 0", done_n, evt_o, err_o);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // R1 R3 halt, R4 stop grant
    send(0, 0, 1, 8'hFB, 32'h0000_0000, 0, 7'b0010000, "R3"); idle(4);
    send(0, 0, 1, 8'hFB, 32'h0000_0010, 0, 7'b0000001, "R4"); idle(4);
    // R5 remaining table entries
    send(0, 0, 1, 8'hBF, 32'h0, 0, 7'b0000010, "R5"); idle(4);
    send(0, 0, 1, 8'hEF, 32'h0, 0, 7'b0000100, "R5"); idle(4);
    send(0, 0, 1, 8'hF7, 32'h0, 0, 7'b0001000, "R5"); idle(4);
    send(0, 0, 1, 8'hFD, 32'h0, 0, 7'b0100000, "R5"); idle(4);
    send(0, 0, 1, 8'hFE, 32'h0, 0, 7'b1000000, "R5"); idle(4);
    // R6 unknown encodings still answered
    send(0, 0, 1, 8'h7F, 32'h0,         1, 7'b0, "R6"); idle(4);
    send(0, 0, 1, 8'hFB, 32'h0000_0008, 1, 7'b0, "R6"); idle(4);
    send(0, 0, 1, 8'hBF, 32'h0000_0010, 1, 7'b0, "R6"); idle(4);
    send(0, 0, 1, 8'hFB, 32'h0000_0020, 1, 7'b0, "R6"); idle(4);
    send(0, 0, 1, 8'hFE, 32'h8000_0000, 1, 7'b0, "R6"); idle(4);
    // R8 non-special cycles ignored (monitor flags any answer)
    send(1, 0, 1, 8'hFB, 32'h0, 0, 7'b0, "R8"); idle(4);
    send(0, 1, 1, 8'hFB, 32'h0, 0, 7'b0, "R8"); idle(4);
    send(0, 0, 0, 8'hFB, 32'h0, 0, 7'b0, "R8"); idle(4);
    // R9 strobes during the wait are dropped
    send(0, 0, 1, 8'hFB, 32'h0, 0, 7'b0010000, "R9");
    send(0, 0, 1, 8'hFE, 32'h0, 0, 7'b1000000, "R9");
    send(0, 0, 1, 8'hEF, 32'h0, 0, 7'b0000100, "R9");
    idle(4);
    // R9 R2 strobe in the ready clock is taken
    send(0, 0, 1, 8'hFD, 32'h0, 0, 7'b0100000, "R9");
    idle(LAT - 1);
    send(0, 0, 1, 8'hF7, 32'h0, 0, 7'b0001000, "R9");
    idle(LAT - 1);
    send(0, 0, 1, 8'h00, 32'h0, 1, 7'b0, "R9");
    idle(8);

    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d answers missing, expected 0", sb.size());
    end
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule